// File: doc/BRIEF.md
# Coherent Timestamp Fetcher

This block reads a free-running 64-bit time counter that can only be reached as two 32-bit words over a simple read port, and hands back a 64-bit value that is free of the split-read hazard. Such a counter has a one-cycle window in which the upper word has already taken the carry while the lower word still shows its pre-carry value. A pair of half reads that straddles the carry can therefore return a time that is far ahead, or behind, the real count. The fetcher fixes this in hardware, so no software has to re-read or compare.

A client pulses `req` with `mode` chosen. The block then issues one or two 64-bit samples on the bus, each as a low-word read followed by a high-word read. In threshold mode, a first sample whose low word is at or above a programmable threshold is thrown away and the counter is sampled again. In pair mode, two samples are always taken and the rule picks which one to trust. The answer appears on `result` with a one-cycle `result_valid` strobe. `corrected` records whether the fix-up path was used.

The threshold resets to 0xFFFFFFFC, which suits a counter that advances by one per bus clock with a two-cycle gap between the half reads. It can be rewritten for other counter rates or bus latencies.

Top module: `ts_fetch`

## Requirements
- R1: After reset `busy`, `result_valid`, `bus_req` and `corrected` are 0 and `result` is all zeros.
- R2: A `req` is accepted only while `busy` is 0. A `req` raised while `busy` is 1 causes no extra bus reads and no extra `result_valid`.
- R3: Every 64-bit sample is one read with `bus_hi`=0 (low word) followed directly by one read with `bus_hi`=1 (high word). `bus_req` and `bus_hi` stay unchanged until `bus_ack` is seen, and `bus_req` is 0 whenever `busy` is 0.
- R4: Threshold mode (`mode`=0), first low word below the threshold: the first sample is returned, `corrected`=0, and exactly two bus reads are made.
- R5: Threshold mode, first low word equal to or above the threshold (unsigned): a second sample is taken and returned, `corrected`=1, and four bus reads are made.
- R6: Pair mode (`mode`=1): two samples are always taken (four reads). If the second is strictly greater than the first (unsigned 64-bit), the first is returned with `corrected`=1.
- R7: Pair mode, second sample not greater than the first: the second is returned with `corrected`=0.
- R8: `result_valid` is high for exactly one cycle. `busy` rises in the cycle after acceptance and falls in the cycle `result_valid` rises. `result` and `corrected` hold until the next `result_valid`.
- R9: The threshold resets to 0xFFFFFFFC. A cycle with `thr_wr`=1 loads `thr_wdata`, and later requests use the new value.
- R10: Against a counter whose upper word may advance between the two half reads, every returned value lies between the true count at acceptance and the true count at `result_valid`, and successive results never decrease.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thr_wr | input | 1 | Load strobe for the threshold |
| thr_wdata | input | HALF_W | New threshold value |
| req | input | 1 | Fetch request |
| mode | input | 1 | 0 = threshold re-read, 1 = pair compare-and-select |
| busy | output | 1 | Fetch in progress |
| result_valid | output | 1 | One-cycle strobe: result is new |
| result | output | 2*HALF_W | Coherent 64-bit timestamp |
| corrected | output | 1 | The fix-up path was used for the latest result |
| bus_req | output | 1 | Read request to the counter |
| bus_hi | output | 1 | 0 = low word, 1 = high word |
| bus_ack | input | 1 | Read acknowledge; `bus_rdata` valid |
| bus_rdata | input | HALF_W | Read data from the counter |

## Verification
The checker assumes the counter port gives at most one `bus_ack` per pending read, and only while `bus_req` is high. It also assumes `mode` and the threshold do not change while a fetch is in flight, since the checker captures both at acceptance. The bench's counter model raises `bus_ack` for one cycle against a pending read and then drops it before it serves the next. Threshold writes and mode changes are made only while the block is idle. The race is provoked by preloading the model's count a few ticks before the low-word wrap, at random offsets.

// File: rtl/ts_fetch_pkg.sv
package ts_fetch_pkg;

   // sequencing of a whole fetch
   typedef enum logic [1:0] {
      FS_IDLE   = 2'd0,
      FS_FIRST  = 2'd1,
      FS_SECOND = 2'd2
   } fetch_st_e;

   // phases of one 64-bit sample on the read port
   typedef enum logic [1:0] {
      RP_IDLE = 2'd0,
      RP_LOW  = 2'd1,
      RP_HIGH = 2'd2
   } read_ph_e;

   localparam logic MODE_THRESH = 1'b0;
   localparam logic MODE_PAIR   = 1'b1;

endpackage

// File: rtl/ts_pair_reader.sv
module ts_pair_reader
   import ts_fetch_pkg::*;
#(
   parameter int HALF_W = 32,
   localparam int TS_W  = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              bus_req,
   output logic              bus_hi,
   input  logic              bus_ack,
   input  logic [HALF_W-1:0] bus_rdata,
   output logic              done,
   output logic [TS_W-1:0]   sample
);

   read_ph_e            ph_q;
   logic [HALF_W-1:0]   lo_q;
   logic [TS_W-1:0]     smp_q;
   logic                done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= RP_IDLE;
         lo_q   <= '0;
         smp_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (ph_q)
            RP_IDLE: begin
               if (start) ph_q <= RP_LOW;
            end
            RP_LOW: begin
               if (bus_ack) begin
                  lo_q <= bus_rdata;
                  ph_q <= RP_HIGH;
               end
            end
            RP_HIGH: begin
               if (bus_ack) begin
                  smp_q  <= {bus_rdata, lo_q};
                  done_q <= 1'b1;
                  ph_q   <= RP_IDLE;
               end
            end
            default: ph_q <= RP_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_req = (ph_q != RP_IDLE);
      bus_hi  = (ph_q == RP_HIGH);
      done    = done_q;
      sample  = smp_q;
   end

endmodule

// File: rtl/ts_thresh_reg.sv
module ts_thresh_reg #(
   parameter int              HALF_W   = 32,
   parameter logic [HALF_W-1:0] THR_INIT = ~HALF_W'(3),
   parameter bit              WRITABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [HALF_W-1:0] wdata,
   output logic [HALF_W-1:0] thr
);

   generate
      if (WRITABLE) begin : g_reg
         logic [HALF_W-1:0] thr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  thr_q <= THR_INIT;
            else if (wr) thr_q <= wdata;
         end
         assign thr = thr_q;
      end else begin : g_const
         assign thr = THR_INIT;
      end
   endgenerate

endmodule

// File: rtl/ts_pick.sv
module ts_pick
   import ts_fetch_pkg::*;
#(
   parameter int HALF_W = 32,
   localparam int TS_W  = 2 * HALF_W
) (
   input  logic              pair_mode,
   input  logic [HALF_W-1:0] thr,
   input  logic [TS_W-1:0]   older,
   input  logic [TS_W-1:0]   fresh,
   output logic              reread,
   output logic [TS_W-1:0]   sel,
   output logic              sel_corr
);

   logic newer_ahead;

   always_comb begin
      // fresh is the sample just finished; in the first stage it is the probe
      reread      = (fresh[HALF_W-1:0] >= thr);
      newer_ahead = (fresh > older);
      if (pair_mode == MODE_PAIR) begin
         sel      = newer_ahead ? older : fresh;
         sel_corr = newer_ahead;
      end else begin
         sel      = fresh;
         sel_corr = 1'b1;
      end
   end

endmodule

// File: rtl/ts_fetch.sv
module ts_fetch
   import ts_fetch_pkg::*;
#(
   parameter int                HALF_W       = 32,
   parameter logic [HALF_W-1:0] THR_INIT     = ~HALF_W'(3),
   parameter bit                THR_WRITABLE = 1'b1,
   localparam int               TS_W         = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              thr_wr,
   input  logic [HALF_W-1:0] thr_wdata,
   input  logic              req,
   input  logic              mode,
   output logic              busy,
   output logic              result_valid,
   output logic [TS_W-1:0]   result,
   output logic              corrected,
   output logic              bus_req,
   output logic              bus_hi,
   input  logic              bus_ack,
   input  logic [HALF_W-1:0] bus_rdata
);

   generate
      if (HALF_W < 8 || HALF_W > 64) begin : g_bad_width
         $error("ts_fetch: HALF_W must lie in 8..64");
      end
   endgenerate

   fetch_st_e         st_q;
   logic              mode_q;
   logic [TS_W-1:0]   first_q;
   logic [TS_W-1:0]   res_q;
   logic              corr_q;
   logic              vld_q;

   logic              smp_start;
   logic              smp_done;
   logic [TS_W-1:0]   smp_val;
   logic [HALF_W-1:0] thr;
   logic              reread;
   logic [TS_W-1:0]   pick_val;
   logic              pick_corr;
   logic              need_second;

   ts_thresh_reg #(
      .HALF_W   (HALF_W),
      .THR_INIT (THR_INIT),
      .WRITABLE (THR_WRITABLE)
   ) u_thr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (thr_wr),
      .wdata (thr_wdata),
      .thr   (thr)
   );

   ts_pair_reader #(
      .HALF_W (HALF_W)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (smp_start),
      .bus_req   (bus_req),
      .bus_hi    (bus_hi),
      .bus_ack   (bus_ack),
      .bus_rdata (bus_rdata),
      .done      (smp_done),
      .sample    (smp_val)
   );

   ts_pick #(
      .HALF_W (HALF_W)
   ) u_pick (
      .pair_mode (mode_q),
      .thr       (thr),
      .older     (first_q),
      .fresh     (smp_val),
      .reread    (reread),
      .sel       (pick_val),
      .sel_corr  (pick_corr)
   );

   always_comb begin
      need_second = (mode_q == MODE_PAIR) || reread;
      smp_start   = ((st_q == FS_IDLE) && req) ||
                    ((st_q == FS_FIRST) && smp_done && need_second);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= FS_IDLE;
         mode_q  <= MODE_THRESH;
         first_q <= '0;
         res_q   <= '0;
         corr_q  <= 1'b0;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         case (st_q)
            FS_IDLE: begin
               if (req) begin
                  mode_q <= mode;
                  st_q   <= FS_FIRST;
               end
            end
            FS_FIRST: begin
               if (smp_done) begin
                  first_q <= smp_val;
                  if (need_second) begin
                     st_q <= FS_SECOND;
                  end else begin
                     res_q  <= smp_val;
                     corr_q <= 1'b0;
                     vld_q  <= 1'b1;
                     st_q   <= FS_IDLE;
                  end
               end
            end
            FS_SECOND: begin
               if (smp_done) begin
                  res_q  <= pick_val;
                  corr_q <= pick_corr;
                  vld_q  <= 1'b1;
                  st_q   <= FS_IDLE;
               end
            end
            default: st_q <= FS_IDLE;
         endcase
      end
   end

   always_comb begin
      busy         = (st_q != FS_IDLE);
      result_valid = vld_q;
      result       = res_q;
      corrected    = corr_q;
   end

endmodule

// File: rtl/ts_fetch_chk.sv
module ts_fetch_chk #(
   parameter int                HALF_W   = 32,
   parameter logic [HALF_W-1:0] THR_INIT = ~HALF_W'(3)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              thr_wr,
   input logic [HALF_W-1:0] thr_wdata,
   input logic              req,
   input logic              mode,
   input logic              busy,
   input logic              result_valid,
   input logic [HALF_W-1:0] res_lo,
   input logic              corrected,
   input logic              bus_req,
   input logic              bus_hi,
   input logic              bus_ack
);

   logic [HALF_W-1:0] thr_m;
   logic [HALF_W-1:0] thr_at_acc;
   logic              mode_at_acc;
   logic [2:0]        n_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_m       <= THR_INIT;
         thr_at_acc  <= THR_INIT;
         mode_at_acc <= 1'b0;
         n_ack       <= '0;
      end else begin
         if (thr_wr) thr_m <= thr_wdata;
         if (req && !busy) begin
            thr_at_acc  <= thr_m;
            mode_at_acc <= mode;
            n_ack       <= '0;
         end else if (bus_req && bus_ack && n_ack != 3'd7) begin
            n_ack <= n_ack + 3'd1;
         end
      end
   end

   a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   a_r8_idle_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> !busy);

   a_r8_busy_ends_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> result_valid);

   a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy) |=> busy);

   a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_hi)));

   a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req);

   a_r3_low_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> !bus_hi);

   a_r4_below_thr: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && !mode_at_acc && !corrected) |->
         ((res_lo < thr_at_acc) && (n_ack == 3'd2)));

   a_r5_reread_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && !mode_at_acc && corrected) |-> (n_ack == 3'd4));

   a_r6_pair_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && mode_at_acc) |-> (n_ack == 3'd4));

endmodule

bind ts_fetch ts_fetch_chk #(
   .HALF_W   (HALF_W),
   .THR_INIT (THR_INIT)
) u_ts_fetch_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .thr_wr       (thr_wr),
   .thr_wdata    (thr_wdata),
   .req          (req),
   .mode         (mode),
   .busy         (busy),
   .result_valid (result_valid),
   .res_lo       (result[HALF_W-1:0]),
   .corrected    (corrected),
   .bus_req      (bus_req),
   .bus_hi       (bus_hi),
   .bus_ack      (bus_ack)
);

// File: tb/test_ts_fetch.sv
`timescale 1ns/1ps
module test_ts_fetch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        thr_wr = 1'b0;
   logic [31:0] thr_wdata = '0;
   logic        req = 1'b0;
   logic        mode = 1'b0;
   logic        busy;
   logic        result_valid;
   logic [63:0] result;
   logic        corrected;
   logic        bus_req;
   logic        bus_hi;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = '0;

   ts_fetch i_ts_fetch (
      .clk          (clk),
      .rst_n        (rst_n),
      .thr_wr       (thr_wr),
      .thr_wdata    (thr_wdata),
      .req          (req),
      .mode         (mode),
      .busy         (busy),
      .result_valid (result_valid),
      .result       (result),
      .corrected    (corrected),
      .bus_req      (bus_req),
      .bus_hi       (bus_hi),
      .bus_ack      (bus_ack),
      .bus_rdata    (bus_rdata)
   );

   initial forever #4 clk = ~clk;   // 125 MHz

   // counter model state
   logic [63:0] cnt = '0;
   logic [63:0] pl_val = '0;
   int          pl_seq = 0;
   int          pl_seen = 0;
   bit          run = 1'b0;
   int          n_reads = 0;
   logic [31:0] rlog [256];
   logic [31:0] thr_m = 32'hFFFF_FFFC;

   int pass_n = 0;
   int total_n = 0;

   // {mode, run, hi, lo}
   localparam logic [65:0] VEC [11] = '{
      {1'b0, 1'b0, 32'h0000_0012, 32'h0000_1000},
      {1'b0, 1'b0, 32'h0000_0034, 32'hFFFF_FFFB},
      {1'b0, 1'b0, 32'h0000_0056, 32'hFFFF_FFFC},
      {1'b0, 1'b0, 32'h0000_0078, 32'hFFFF_FFFF},
      {1'b1, 1'b0, 32'h0000_009A, 32'h0000_0005},
      {1'b0, 1'b1, 32'h0000_00D0, 32'hFFFF_FFFD},
      {1'b0, 1'b1, 32'h0000_00D1, 32'hFFFF_FFFA},
      {1'b1, 1'b1, 32'h0000_00D2, 32'hFFFF_FFF9},
      {1'b1, 1'b1, 32'h0000_00D3, 32'hFFFF_FFFB},
      {1'b1, 1'b1, 32'h0000_00D4, 32'hFFFF_FFFC},
      {1'b0, 1'b1, 32'h0000_00D5, 32'h7FFF_FFFE}
   };

   // counter and read responder: one ack cycle per read, then a gap
   initial begin
      for (int i = 0; i < 256; i++) rlog[i] = '0;
      forever begin
         @(negedge clk);
         if (pl_seq != pl_seen) begin
            cnt     = pl_val;
            pl_seen = pl_seq;
         end else if (run) begin
            cnt = cnt + 64'd1;
         end
         if (bus_ack) begin
            bus_ack = 1'b0;
         end else if (bus_req && rst_n) begin
            bus_rdata = bus_hi ? cnt[63:32] : cnt[31:0];
            rlog[n_reads % 256] = bus_rdata;
            n_reads = n_reads + 1;
            bus_ack = 1'b1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total_n++;
      if (ok) pass_n++;
      else $display("FAIL %s: actual %h expected %h", tag, act, exp);
   endtask

   task automatic preload(input logic [63:0] v, input bit r);
      @(negedge clk); #1;
      run    = r;
      pl_val = v;
      pl_seq = pl_seq + 1;
      @(negedge clk); #1;
   endtask

   task automatic fetch(input bit m, output logic [63:0] r, output bit c,
                        output int b, output int nr,
                        output logic [63:0] t0, output logic [63:0] t1);
      int k;
      @(negedge clk); #1;
      b    = n_reads;
      mode = m;
      req  = 1'b1;
      t0   = cnt;
      @(negedge clk); #1;
      req = 1'b0;
      k = 0;
      while (!result_valid && k < 200) begin
         @(negedge clk); #1;
         k++;
      end
      t1 = cnt;
      r  = result;
      c  = corrected;
      nr = n_reads - b;
   endtask

   // expectation from the words the model served, per R4..R7
   task automatic judge(input bit m, input int b, input int nr,
                        input logic [63:0] r, input bit c);
      logic [63:0] s1, s2, e;
      bit ec;
      int en;
      string tg;
      s1 = {rlog[(b + 1) % 256], rlog[b % 256]};
      s2 = {rlog[(b + 3) % 256], rlog[(b + 2) % 256]};
      if (!m) begin
         if (s1[31:0] >= thr_m) begin e = s2; ec = 1'b1; en = 4; tg = "R5"; end
         else                   begin e = s1; ec = 1'b0; en = 2; tg = "R4"; end
      end else begin
         en = 4;
         if (s2 > s1) begin e = s1; ec = 1'b1; tg = "R6"; end
         else         begin e = s2; ec = 1'b0; tg = "R7"; end
      end
      chk(r == e, {tg, " result"}, r, e);
      chk(c == ec, {tg, " corrected"}, 64'(c), 64'(ec));
      chk(nr == en, "R3 read count", 64'(nr), 64'(en));
   endtask

   task automatic write_thr(input logic [31:0] v);
      @(negedge clk); #1;
      thr_wr    = 1'b1;
      thr_wdata = v;
      @(negedge clk); #1;
      thr_wr = 1'b0;
      thr_m  = v;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", pass_n, total_n);
      $finish;
   endtask

   initial begin
      #1_000_000;
      total_n++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [63:0] r, t0, t1, prev, held;
      bit c;
      int b, nr, k;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!busy && !result_valid && !bus_req, "R1 idle flags in reset", {61'b0, busy, result_valid, bus_req}, 64'd0);
      #1 rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk(result == 64'd0, "R1 result after reset", result, 64'd0);
      chk(!corrected && !busy && !bus_req, "R1 flags after reset", {61'b0, corrected, busy, bus_req}, 64'd0);

      // table walk: R3..R7, R9 (reset threshold at 0xFFFFFFFC), R10
      for (int i = 0; i < 11; i++) begin
         preload(VEC[i][63:0], VEC[i][64]);
         fetch(VEC[i][65], r, c, b, nr, t0, t1);
         judge(VEC[i][65], b, nr, r, c);
         if (VEC[i][64])
            chk(r >= t0 && r <= t1, "R10 window", r, t0);
      end

      // R9: boundary of the reset threshold, frozen counter
      preload({32'h1, 32'hFFFF_FFFC}, 1'b0);
      fetch(1'b0, r, c, b, nr, t0, t1);
      chk(c == 1'b1, "R9 reset threshold at 0xFFFFFFFC", 64'(c), 64'd1);
      preload({32'h1, 32'hFFFF_FFFB}, 1'b0);
      fetch(1'b0, r, c, b, nr, t0, t1);
      chk(c == 1'b0, "R9 reset threshold below", 64'(c), 64'd0);

      // R9: reprogrammed threshold
      write_thr(32'h0000_0100);
      preload({32'h2, 32'h0000_0100}, 1'b0);
      fetch(1'b0, r, c, b, nr, t0, t1);
      chk(c == 1'b1 && nr == 4, "R9 new threshold met", {63'b0, c}, 64'd1);
      preload({32'h2, 32'h0000_00FF}, 1'b0);
      fetch(1'b0, r, c, b, nr, t0, t1);
      chk(c == 1'b0 && nr == 2, "R9 new threshold not met", {63'b0, c}, 64'd0);
      chk(r == {32'h2, 32'h0000_00FF}, "R4 first sample kept", r, {32'h2, 32'h0000_00FF});
      write_thr(32'hFFFF_FFFC);

      // R8: busy/valid timing and hold
      preload({32'h3, 32'h0000_0040}, 1'b0);
      @(negedge clk); #1;
      mode = 1'b0;
      req  = 1'b1;
      @(negedge clk); #1;
      req = 1'b0;
      chk(busy == 1'b1, "R8 busy after accept", 64'(busy), 64'd1);
      k = 0;
      while (!result_valid && k < 200) begin
         chk(busy == 1'b1, "R8 busy while pending", 64'(busy), 64'd1);
         @(negedge clk); #1;
         k++;
      end
      chk(result_valid && !busy, "R8 busy low at valid", {62'b0, result_valid, busy}, 64'd2);
      held = result;
      @(negedge clk); #1;
      chk(!result_valid, "R8 one-cycle valid", 64'(result_valid), 64'd0);
      repeat (3) @(negedge clk);
      #1;
      chk(result == held && corrected == 1'b0, "R8 result held", result, held);

      // R2: request while busy ignored
      preload({32'h4, 32'h0000_0010}, 1'b0);
      @(negedge clk); #1;
      b    = n_reads;
      mode = 1'b0;
      req  = 1'b1;
      @(negedge clk); #1;
      req = 1'b0;
      @(negedge clk); #1;
      req = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      req = 1'b0;
      k = 0;
      while (!result_valid && k < 200) begin
         @(negedge clk); #1;
         k++;
      end
      k = 0;
      for (int j = 0; j < 8; j++) begin
         @(negedge clk); #1;
         if (result_valid || busy) k++;
      end
      chk(n_reads - b == 2, "R2 reads for one accepted request", 64'(n_reads - b), 64'd2);
      chk(k == 0, "R2 no second fetch", 64'(k), 64'd0);

      // R10: race injection at random carry points, monotonic results
      for (int i = 0; i < 30; i++) begin
         bit m;
         m = 1'($urandom_range(0, 1));
         preload({$urandom, 32'hFFFF_FFFF - 32'($urandom_range(0, 12))}, 1'b1);
         fetch(m, r, c, b, nr, t0, t1);
         judge(m, b, nr, r, c);
         chk(r >= t0 && r <= t1, "R10 window", r, t0);
         prev = r;
         fetch(~m, r, c, b, nr, t0, t1);
         judge(~m, b, nr, r, c);
         chk(r >= t0 && r <= t1, "R10 window", r, t0);
         chk(r >= prev, "R10 monotonic", r, prev);
      end

      finish_run();
   end

endmodule